// File: doc/BRIEF.md
# Dual-Domain MAC Enable Synchronizer

This block holds the receive-enable and transmit-enable controls of an Ethernet MAC, which a host writes in its register clock domain. Each control is carried into the clock domain where it is used: the receive enable goes to the receive line clock and the transmit enable goes to the transmit line clock. Both line clocks come from the PHY. The MAC datapath acts only on the line-domain copy, so a host write has no effect on a path until the value has crossed into that path's clock.

Each line-domain enable is then carried back into the host clock domain as a status bit. Software polls the status after writing an enable to confirm that the path has really switched. The two paths are fully independent. The line-domain reset is released by the line clock itself, so a path whose clock is absent stays in reset. Its enable and its status then stay low whatever the host writes.

Top module: `mac_enable_sync`

## Requirements
- R1: While `host_rst_n` is low, `reg_rd_data` is all zero and both `rx_en_line` and `tx_en_line` are low. Reset acts asynchronously.
- R2: On a rising `host_clk` edge with `reg_wr_en` high, the receive control takes `reg_wr_data[0]` and the transmit control takes `reg_wr_data[1]`. Bits above 1 are ignored. Without a write, both controls keep their value.
- R3: `reg_rd_data` reports the receive control at bit 0, the transmit control at bit 1, the receive status at bit 2 and the transmit status at bit 3. All higher bits read zero.
- R4: `rx_en_line` follows the receive control after at least SYNC_STAGES-1 and at most SYNC_STAGES+1 rising `rx_clk` edges.
- R5: `rx_en_status` follows `rx_en_line` within SYNC_STAGES+1 rising `host_clk` edges. It is still low at the moment `rx_en_line` first rises.
- R6: The transmit path behaves as in R4 and R5, using `tx_clk`, `tx_en_line` and `tx_en_status`.
- R7: Clearing an enable propagates along the same path. A status bit returns to zero only after its line enable has gone low.
- R8: If a line clock has not toggled since reset, that path's line enable and status stay zero whatever the host writes.
- R9: The receive and transmit paths are independent. Writing or stopping one path leaves the other path's control, line enable and status unchanged.
- R10: A status bit is never set unless its control bit has been set at some point since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| host_rst_n | input | 1 | Asynchronous active-low reset, host domain |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_data | output | DATA_W | Register read data: controls and status |
| rx_clk | input | 1 | Receive line clock from the PHY |
| tx_clk | input | 1 | Transmit line clock from the PHY |
| rx_en_line | output | 1 | Receive enable in the `rx_clk` domain |
| tx_en_line | output | 1 | Transmit enable in the `tx_clk` domain |
| rx_en_status | output | 1 | Receive enable reflected back to the host domain |
| tx_en_status | output | 1 | Transmit enable reflected back to the host domain |

## Verification
The bench builds the block with SYNC_STAGES = 3 and DATA_W = 8. It drives a 10 ns host clock, a 14.3 ns receive clock and a 19.3 ns transmit clock, which are unrelated to one another. Three synchronizer stages make the edge-count windows of R4 and R5 wide enough to tell a lane that skips or adds a stage from one that is correct. The eight-bit data word leaves upper write bits that R2 must ignore. The line clocks can be gated, which brings the stopped-clock cases of R8 and the independence case of R9 within reach.

// File: rtl/mes_pkg.sv
`timescale 1ns/1ps
package mes_pkg;
  localparam int NUM_LANES = 2;
  localparam int RX_LANE   = 0;
  localparam int TX_LANE   = 1;
  localparam int CTRL_LSB  = 0;
  localparam int STAT_LSB  = CTRL_LSB + NUM_LANES;
  localparam int FIELD_W   = STAT_LSB + NUM_LANES;
  typedef logic [NUM_LANES-1:0] lane_vec_t;
endpackage

// File: rtl/mes_sync_bit.sv
`timescale 1ns/1ps
module mes_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mes_rst_sync.sv
`timescale 1ns/1ps
module mes_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  mes_sync_bit #(.STAGES(STAGES)) u_rel (
    .clk   (clk),
    .rst_n (arst_n),
    .d     (1'b1),
    .q     (rst_n_out)
  );
endmodule

// File: rtl/mes_enable_lane.sv
`timescale 1ns/1ps
module mes_enable_lane #(
  parameter int STAGES = 2
) (
  input  logic host_clk,
  input  logic host_rst_n,
  input  logic line_clk,
  input  logic ctrl,
  output logic line_en,
  output logic status
);
  logic line_rst_n;

  // line reset releases only on line clock edges: absent clock keeps lane off
  mes_rst_sync #(.STAGES(STAGES)) u_line_rst (
    .clk       (line_clk),
    .arst_n    (host_rst_n),
    .rst_n_out (line_rst_n)
  );

  mes_sync_bit #(.STAGES(STAGES)) u_fwd (
    .clk   (line_clk),
    .rst_n (line_rst_n),
    .d     (ctrl),
    .q     (line_en)
  );

  mes_sync_bit #(.STAGES(STAGES)) u_back (
    .clk   (host_clk),
    .rst_n (host_rst_n),
    .d     (line_en),
    .q     (status)
  );
endmodule

// File: rtl/mac_enable_sync.sv
`timescale 1ns/1ps
module mac_enable_sync
  import mes_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              host_clk,
  input  logic              host_rst_n,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              rx_clk,
  input  logic              tx_clk,
  output logic              rx_en_line,
  output logic              tx_en_line,
  output logic              rx_en_status,
  output logic              tx_en_status
);
  lane_vec_t ctrl_q;
  lane_vec_t ctrl_d;
  lane_vec_t lane_clk;
  lane_vec_t lane_en;
  lane_vec_t lane_stat;
  logic      wr_unused;

  assign wr_unused = ^reg_wr_data[DATA_W-1:NUM_LANES];

  // control register: next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr_en) begin
      ctrl_d = reg_wr_data[NUM_LANES-1:0];
    end
  end

  // control register: state
  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign lane_clk[RX_LANE] = rx_clk;
  assign lane_clk[TX_LANE] = tx_clk;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    mes_enable_lane #(.STAGES(SYNC_STAGES)) u_lane (
      .host_clk   (host_clk),
      .host_rst_n (host_rst_n),
      .line_clk   (lane_clk[g]),
      .ctrl       (ctrl_q[g]),
      .line_en    (lane_en[g]),
      .status     (lane_stat[g])
    );
  end

  always_comb begin
    reg_rd_data = '0;
    reg_rd_data[CTRL_LSB +: NUM_LANES] = ctrl_q;
    reg_rd_data[STAT_LSB +: NUM_LANES] = lane_stat;
  end

  assign rx_en_line   = lane_en[RX_LANE];
  assign tx_en_line   = lane_en[TX_LANE];
  assign rx_en_status = lane_stat[RX_LANE];
  assign tx_en_status = lane_stat[TX_LANE];
endmodule

// File: rtl/mac_enable_sync_chk.sv
`timescale 1ns/1ps
module mac_enable_sync_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input logic              host_clk,
  input logic              host_rst_n,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic              rx_clk,
  input logic              tx_clk,
  input logic              rx_en_line,
  input logic              tx_en_line,
  input logic              rx_en_status,
  input logic              tx_en_status
);
  logic [1:0] ctrl_seen;
  logic       rx_ran;
  logic       tx_ran;

  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) ctrl_seen <= '0;
    else             ctrl_seen <= ctrl_seen | reg_rd_data[1:0];
  end

  always_ff @(posedge rx_clk or negedge host_rst_n) begin
    if (!host_rst_n) rx_ran <= 1'b0;
    else             rx_ran <= 1'b1;
  end

  always_ff @(posedge tx_clk or negedge host_rst_n) begin
    if (!host_rst_n) tx_ran <= 1'b0;
    else             tx_ran <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge host_clk)
    $rose(host_rst_n) |-> (reg_rd_data == '0 && !rx_en_status && !tx_en_status));

  // R2
  wr_capture_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    reg_wr_en |=> reg_rd_data[1:0] == $past(reg_wr_data[1:0]));

  // R2
  ctrl_hold_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    !reg_wr_en |=> $stable(reg_rd_data[1:0]));

  // R10
  rx_stat_cause_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    rx_en_status |-> ctrl_seen[0]);

  // R10
  tx_stat_cause_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    tx_en_status |-> ctrl_seen[1]);

  // R8
  rx_noclk_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    !rx_ran |-> (!rx_en_status && !rx_en_line));

  // R8
  tx_noclk_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    !tx_ran |-> (!tx_en_status && !tx_en_line));
endmodule

bind mac_enable_sync mac_enable_sync_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .DATA_W      (DATA_W)
) u_chk (
  .host_clk     (host_clk),
  .host_rst_n   (host_rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_data  (reg_wr_data),
  .reg_rd_data  (reg_rd_data),
  .rx_clk       (rx_clk),
  .tx_clk       (tx_clk),
  .rx_en_line   (rx_en_line),
  .tx_en_line   (tx_en_line),
  .rx_en_status (rx_en_status),
  .tx_en_status (tx_en_status)
);

// File: tb/mac_enable_sync_bench.sv
`timescale 1ns/1ps
module mac_enable_sync_bench;
  localparam real CLK_PERIOD = 10.0;
  localparam real RX_HALF    = 7.15;
  localparam real TX_HALF    = 9.65;
  localparam int  STG        = 3;
  localparam int  DW         = 8;
  localparam int  NVEC       = 7;
  localparam int  SETTLE     = 60;
  localparam int  CLR_BOUND  = 20;
  // {write data, expected read data once settled}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h01, 8'h05}, {8'h03, 8'h0F}, {8'h02, 8'h0A}, {8'h00, 8'h00},
    {8'hF2, 8'h0A}, {8'hFC, 8'h00}, {8'h01, 8'h05}
  };

  logic          host_clk = 1'b0;
  logic          rx_clk = 1'b0;
  logic          tx_clk = 1'b0;
  logic          rx_run = 1'b1;
  logic          tx_run = 1'b1;
  logic          host_rst_n;
  logic          reg_wr_en;
  logic [DW-1:0] reg_wr_data;
  logic [DW-1:0] reg_rd_data;
  logic          rx_en_line, tx_en_line, rx_en_status, tx_en_status;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD / 2.0) host_clk = ~host_clk;
  always begin #(RX_HALF); if (rx_run) rx_clk = ~rx_clk; end
  always begin #(TX_HALF); if (tx_run) tx_clk = ~tx_clk; end

  mac_enable_sync #(.SYNC_STAGES(STG), .DATA_W(DW)) u_mac_enable_sync (
    .host_clk     (host_clk),
    .host_rst_n   (host_rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_data  (reg_rd_data),
    .rx_clk       (rx_clk),
    .tx_clk       (tx_clk),
    .rx_en_line   (rx_en_line),
    .tx_en_line   (tx_en_line),
    .rx_en_status (rx_en_status),
    .tx_en_status (tx_en_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] v);
    @(negedge host_clk);
    reg_wr_data = v;
    reg_wr_en   = 1'b1;
    @(posedge host_clk);
    #1 reg_wr_en = 1'b0;
  endtask

  task automatic wait_host(input int n);
    repeat (n) @(posedge host_clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge host_clk);
    host_rst_n = 1'b0;
    wait_host(3);
    @(negedge host_clk);
    host_rst_n = 1'b1;
    wait_host(20);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int  n;
    int  m;
    bit  early;
    bit  bad_order;
    host_rst_n  = 1'b0;
    reg_wr_en   = 1'b0;
    reg_wr_data = '0;
    wait_host(4);
    // R1: reset state
    check(reg_rd_data == 8'h00 && !rx_en_line && !tx_en_line, "R1 reset state",
          {reg_rd_data, 6'b0, rx_en_line, tx_en_line}, 0);
    @(negedge host_clk);
    host_rst_n = 1'b1;
    wait_host(20);

    // R2/R4/R5: receive enable latency
    wr(8'h01);
    check(reg_rd_data == 8'h01, "R2 control visible, R5 status not yet", reg_rd_data, 8'h01);
    n = 0;
    while (!rx_en_line && n < 12) begin
      @(posedge rx_clk);
      #0.5;
      n++;
    end
    early = rx_en_status;
    check(n >= STG - 1 && n <= STG + 1, "R4 rx edges to line enable", n, STG);
    check(!early, "R5 status low when line enable rises", early, 0);
    m = 0;
    while (!rx_en_status && m < 12) begin
      @(posedge host_clk);
      #1;
      m++;
    end
    check(m >= 1 && m <= STG + 1, "R5 host edges to status", m, STG);

    // R2/R3/R9: table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][15:8]);
      wait_host(SETTLE);
      check(reg_rd_data == VEC[i][7:0], "R3 R9 settled read data", reg_rd_data, VEC[i][7:0]);
      check(rx_en_line == VEC[i][0] && tx_en_line == VEC[i][1], "R2 R9 line enables",
            {rx_en_line, tx_en_line}, {VEC[i][0], VEC[i][1]});
    end

    // R6: transmit enable latency (receive already on)
    wr(8'h03);
    n = 0;
    while (!tx_en_line && n < 12) begin
      @(posedge tx_clk);
      #0.5;
      n++;
    end
    early = tx_en_status;
    check(n >= STG - 1 && n <= STG + 1, "R6 tx edges to line enable", n, STG);
    check(!early, "R6 status low when line enable rises", early, 0);
    m = 0;
    while (!tx_en_status && m < 12) begin
      @(posedge host_clk);
      #1;
      m++;
    end
    check(m >= 1 && m <= STG + 1, "R6 host edges to status", m, STG);
    wait_host(SETTLE);

    // R7: clearing the receive enable, order and bound
    wr(8'h02);
    bad_order = 1'b0;
    m = 0;
    while (rx_en_status && m < CLR_BOUND) begin
      @(posedge host_clk);
      #1;
      m++;
      if (!rx_en_status && rx_en_line) bad_order = 1'b1;
    end
    check(!bad_order, "R7 status cleared before line enable", bad_order, 0);
    check(!rx_en_status && m < CLR_BOUND, "R7 status clears in bound", m, STG);
    check(tx_en_status && tx_en_line, "R9 tx kept while rx cleared",
          {tx_en_status, tx_en_line}, 3);

    // R8/R9: receive clock stopped
    rx_run = 1'b0;
    do_reset();
    wr(8'h03);
    wait_host(SETTLE);
    check(reg_rd_data == 8'h0B, "R8 rx status with rx clock stopped", reg_rd_data, 8'h0B);
    check(!rx_en_line, "R8 rx line enable with rx clock stopped", rx_en_line, 0);
    rx_run = 1'b1;
    wait_host(SETTLE);
    check(reg_rd_data == 8'h0F, "R9 rx starts once clock runs", reg_rd_data, 8'h0F);

    // R8/R9: transmit clock stopped
    tx_run = 1'b0;
    do_reset();
    wr(8'h03);
    wait_host(SETTLE);
    check(reg_rd_data == 8'h07, "R8 tx status with tx clock stopped", reg_rd_data, 8'h07);
    check(!tx_en_line && rx_en_line, "R8 R9 line enables with tx stopped",
          {tx_en_line, rx_en_line}, 1);
    tx_run = 1'b1;
    wait_host(SETTLE);
    check(reg_rd_data == 8'h0F, "R9 tx starts once clock runs", reg_rd_data, 8'h0F);

    // R1: reset asserted between edges during operation
    #3 host_rst_n = 1'b0;
    #1;
    check(reg_rd_data == 8'h00 && !rx_en_line && !tx_en_line, "R1 async reset mid-run",
          {reg_rd_data, 6'b0, rx_en_line, tx_en_line}, 0);
    wait_host(3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule